// File: doc/BRIEF.md
# Interval Timer Register Interface

This block is the processor-facing register front end of a three-channel interval timer. A processor writes control words and divider bytes and reads count bytes through a 2-bit address, an 8-bit data bus and separate read and write strobes. Address 3 carries control words. Addresses 0 to 2 reach channel 0 to 2.

A control word either reconfigures one channel's byte-access format or freezes that channel's count in a snapshot register. Every 16-bit quantity moves one byte at a time. A channel can be set to move only its low byte, only its high byte, or the low byte followed by the high byte. A per-channel byte pointer tracks which half comes next. The pointer is shared by reads and writes.

Each channel holds a 16-bit down-counter, advanced by its own count-enable input, so that the readback path has live values to return. The mode and BCD fields of a control word are stored and presented on an output for a downstream waveform stage. This block does not act on them.

Top module: `itmr_regif`

## Requirements
- R1: A write to address 3 is a control word. Bits 7:6 select the channel, and the value 3 is ignored. Bits 5:4 give the format: 00 latch command, 01 low only, 10 high only, 11 low then high. Bits 3:1 are the mode and bit 0 is BCD. A non-latch word stores the format, puts {mode,BCD} on `chan_cfg[4*ch+3:4*ch]`, clears that channel's latched flag, and points the byte pointer at the high byte for high-only format and at the low byte otherwise. It leaves divider and count untouched.
- R2: In low-only or high-only format, a write to a channel address replaces only that byte of the divider. It reloads the counter from the new divider on the same edge and clears the latched flag.
- R3: In two-byte format, the first data write replaces the divider low byte and moves the pointer to the high byte, without reloading the counter. The second write replaces the high byte, reloads the counter, returns the pointer to low and clears the latched flag.
- R4: While its count enable is high, a channel's count drops by one each clock. A count of 1 reloads from the divider instead. A divider of 0 acts as 65536, so 0 is followed by 0xFFFF.
- R5: A read returns bytes of the snapshot while the latched flag is set, and of the live count otherwise. Low-only format returns bits 7:0 and high-only format returns bits 15:8. Either single-byte read clears the latched flag.
- R6: In two-byte format, the first read returns the low byte and moves the pointer to the high byte, keeping the latch. The second read returns the high byte, returns the pointer to low and clears the latched flag.
- R7: A latch command copies the channel's current count into the snapshot and sets the latched flag. It leaves format, mode and pointer unchanged. A latch command on an already latched channel is ignored, so the first snapshot is kept.
- R8: `rdata` is registered and is valid on the cycle after the read strobe. It holds its value on cycles without a read. Reading address 3 returns 0x00 and changes no state.
- R9: When the read and write strobes are both high, only the write takes effect. The read is dropped and `rdata` holds.
- R10: Synchronous active-high reset clears `rdata`, `chan_cfg`, every divider, count and snapshot, every byte pointer (to low) and latched flag. It also sets every format to two-byte.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | 2 | Register address: 0 to 2 channel data, 3 control word |
| wdata | input | 8 | Write data |
| wr_en | input | 1 | Write strobe, one access per high cycle |
| rd_en | input | 1 | Read strobe, one access per high cycle |
| cnt_en | input | 3 | Per-channel count enable |
| rdata | output | 8 | Registered read data |
| chan_cfg | output | 12 | Stored {mode,BCD} per channel, 4 bits each |

## Verification
The bench targets the snapshot lifetime. It counts past a latch and checks that a two-byte read returns the frozen value until the high byte is taken, then live bytes. A design that cleared the latch on the low read would return a torn pair, and one that re-latched on a second command would show the later count. It checks that a half-written divider does not reload the counter, by reading the live count between the two writes. It runs a zero divider through its wrap to 0xFFFF and a small divider through its reload at 1. It also checks that the pointer is shared between reads and writes, that a control-address read disturbs nothing, and that colliding strobes drop the read. A wrong design would show a shifted byte order or a stale or changed `rdata` in these cases.

// File: rtl/itmr_pkg.sv
package itmr_pkg;
  localparam int BYTE_W = 8;
  localparam int CNT_W  = 2 * BYTE_W;
  localparam int CFG_W  = 4;

  typedef enum logic [1:0] {
    FMT_SNAP = 2'b00,
    FMT_LO   = 2'b01,
    FMT_HI   = 2'b10,
    FMT_PAIR = 2'b11
  } fmt_e;
endpackage

// File: rtl/itmr_cword_dec.sv
module itmr_cword_dec
  import itmr_pkg::*;
#(
  parameter int NCH = 3
) (
  input  logic              cw_wr,
  input  logic [BYTE_W-1:0] wdata,
  output logic [NCH-1:0]    cw_load,
  output logic [NCH-1:0]    cw_latch,
  output fmt_e              cw_fmt,
  output logic [CFG_W-1:0]  cw_cfg
);
  logic [1:0] sel;

  assign sel    = wdata[7:6];
  assign cw_fmt = fmt_e'(wdata[5:4]);
  assign cw_cfg = wdata[3:0];

  for (genvar ch = 0; ch < NCH; ch++) begin : g_sel
    logic hit;
    assign hit          = cw_wr && (sel == 2'(ch));
    assign cw_load[ch]  = hit && (cw_fmt != FMT_SNAP);
    assign cw_latch[ch] = hit && (cw_fmt == FMT_SNAP);
  end
endmodule

// File: rtl/itmr_channel.sv
module itmr_channel
  import itmr_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              cnt_en,
  input  logic              cw_load,
  input  logic              cw_latch,
  input  fmt_e              cw_fmt,
  input  logic [CFG_W-1:0]  cw_cfg,
  input  logic              dwr,
  input  logic              rd,
  input  logic [BYTE_W-1:0] wdata,
  output logic [BYTE_W-1:0] rbyte,
  output logic [CFG_W-1:0]  cfg
);
  fmt_e             fmt_q, fmt_n;
  logic [CFG_W-1:0] cfg_q, cfg_n;
  logic [CNT_W-1:0] div_q, div_n;
  logic [CNT_W-1:0] cnt_q, cnt_n;
  logic [CNT_W-1:0] snap_q, snap_n;
  logic             hi_q, hi_n;
  logic             lat_q, lat_n;
  logic             reload;
  logic [CNT_W-1:0] src;

  assign src   = lat_q ? snap_q : cnt_q;
  assign rbyte = (fmt_q == FMT_HI || (fmt_q == FMT_PAIR && hi_q)) ?
                 src[CNT_W-1:BYTE_W] : src[BYTE_W-1:0];
  assign cfg   = cfg_q;

  always_comb begin
    fmt_n  = fmt_q;
    cfg_n  = cfg_q;
    div_n  = div_q;
    snap_n = snap_q;
    hi_n   = hi_q;
    lat_n  = lat_q;
    reload = 1'b0;

    if (cw_load) begin
      fmt_n = cw_fmt;
      cfg_n = cw_cfg;
      hi_n  = (cw_fmt == FMT_HI);
      lat_n = 1'b0;
    end else if (cw_latch && !lat_q) begin
      snap_n = cnt_q;
      lat_n  = 1'b1;
    end

    if (dwr) begin
      unique case (fmt_q)
        FMT_LO: begin
          div_n[BYTE_W-1:0] = wdata;
          reload = 1'b1;
          lat_n  = 1'b0;
        end
        FMT_HI: begin
          div_n[CNT_W-1:BYTE_W] = wdata;
          reload = 1'b1;
          lat_n  = 1'b0;
        end
        FMT_PAIR: begin
          if (hi_q) begin
            div_n[CNT_W-1:BYTE_W] = wdata;
            reload = 1'b1;
            hi_n   = 1'b0;
            lat_n  = 1'b0;
          end else begin
            div_n[BYTE_W-1:0] = wdata;
            hi_n = 1'b1;
          end
        end
        default: ;
      endcase
    end

    if (rd) begin
      unique case (fmt_q)
        FMT_LO, FMT_HI: lat_n = 1'b0;
        FMT_PAIR: begin
          if (hi_q) begin
            hi_n  = 1'b0;
            lat_n = 1'b0;
          end else begin
            hi_n = 1'b1;
          end
        end
        default: ;
      endcase
    end

    if (reload)
      cnt_n = div_n;
    else if (cnt_en)
      cnt_n = (cnt_q == CNT_W'(1)) ? div_q : cnt_q - CNT_W'(1);
    else
      cnt_n = cnt_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      fmt_q  <= FMT_PAIR;
      cfg_q  <= '0;
      div_q  <= '0;
      cnt_q  <= '0;
      snap_q <= '0;
      hi_q   <= 1'b0;
      lat_q  <= 1'b0;
    end else begin
      fmt_q  <= fmt_n;
      cfg_q  <= cfg_n;
      div_q  <= div_n;
      cnt_q  <= cnt_n;
      snap_q <= snap_n;
      hi_q   <= hi_n;
      lat_q  <= lat_n;
    end
  end
endmodule

// File: rtl/itmr_regif.sv
module itmr_regif
  import itmr_pkg::*;
#(
  parameter int NCH = 3
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [1:0]           addr,
  input  logic [BYTE_W-1:0]    wdata,
  input  logic                 wr_en,
  input  logic                 rd_en,
  input  logic [NCH-1:0]       cnt_en,
  output logic [BYTE_W-1:0]    rdata,
  output logic [NCH*CFG_W-1:0] chan_cfg
);
  localparam logic [1:0] CW_ADDR = 2'd3;

  logic                  rd_act;
  logic [NCH-1:0]        cw_load, cw_latch;
  fmt_e                  cw_fmt;
  logic [CFG_W-1:0]      cw_cfg;
  logic [BYTE_W-1:0]     rbyte [NCH];
  logic [BYTE_W-1:0]     sel_byte;

  assign rd_act = rd_en && !wr_en;

  itmr_cword_dec #(.NCH(NCH)) u_dec (
    .cw_wr    (wr_en && addr == CW_ADDR),
    .wdata    (wdata),
    .cw_load  (cw_load),
    .cw_latch (cw_latch),
    .cw_fmt   (cw_fmt),
    .cw_cfg   (cw_cfg)
  );

  for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
    itmr_channel u_ch (
      .clk      (clk),
      .rst      (rst),
      .cnt_en   (cnt_en[ch]),
      .cw_load  (cw_load[ch]),
      .cw_latch (cw_latch[ch]),
      .cw_fmt   (cw_fmt),
      .cw_cfg   (cw_cfg),
      .dwr      (wr_en && addr == 2'(ch)),
      .rd       (rd_act && addr == 2'(ch)),
      .wdata    (wdata),
      .rbyte    (rbyte[ch]),
      .cfg      (chan_cfg[ch*CFG_W +: CFG_W])
    );
  end

  always_comb begin
    sel_byte = '0;
    for (int ch = 0; ch < NCH; ch++)
      if (addr == 2'(ch)) sel_byte = rbyte[ch];
  end

  always_ff @(posedge clk) begin
    if (rst)
      rdata <= '0;
    else if (rd_act)
      rdata <= sel_byte;
  end
endmodule

// File: rtl/itmr_regif_chk.sv
module itmr_regif_chk
  import itmr_pkg::*;
#(
  parameter int NCH = 3
) (
  input logic                 clk,
  input logic                 rst,
  input logic [1:0]           addr,
  input logic [BYTE_W-1:0]    wdata,
  input logic                 wr_en,
  input logic                 rd_en,
  input logic [BYTE_W-1:0]    rdata,
  input logic [NCH*CFG_W-1:0] chan_cfg
);
  assert_reset_clear_R10: assert property (@(posedge clk)
    rst |=> (rdata == '0 && chan_cfg == '0));

  assert_cw_read_zero_R8: assert property (@(posedge clk) disable iff (rst)
    (rd_en && !wr_en && addr == 2'd3) |=> rdata == '0);

  assert_rdata_hold_R8: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> $stable(rdata));

  assert_collide_drop_R9: assert property (@(posedge clk) disable iff (rst)
    (rd_en && wr_en) |=> $stable(rdata));

  assert_cfg_hold_R1: assert property (@(posedge clk) disable iff (rst)
    !(wr_en && addr == 2'd3) |=> $stable(chan_cfg));

  assert_cfg_load_ch0_R1: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr == 2'd3 && wdata[7:6] == 2'd0 && wdata[5:4] != 2'd0)
      |=> chan_cfg[CFG_W-1:0] == $past(wdata[CFG_W-1:0]));
endmodule

bind itmr_regif itmr_regif_chk #(.NCH(NCH)) u_chk (.*);

// File: tb/itmr_regif_bench.sv
`timescale 1ns/1ps
module itmr_regif_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [1:0] addr = '0;
  logic [7:0] wdata = '0;
  logic       wr_en = 1'b0;
  logic       rd_en = 1'b0;
  logic [2:0] cnt_en = '0;
  logic [7:0] rdata;
  logic [11:0] chan_cfg;

  int checks = 0;
  int fails  = 0;
  string cur_req = "R10";

  always #2 clk = ~clk;

  itmr_regif u_itmr_regif (
    .clk(clk), .rst(rst), .addr(addr), .wdata(wdata),
    .wr_en(wr_en), .rd_en(rd_en), .cnt_en(cnt_en),
    .rdata(rdata), .chan_cfg(chan_cfg)
  );

  // Behavioural reference model
  int m_div[3], m_cnt[3], m_snap[3], m_fmt[3], m_cfg[3];
  bit m_lat[3], m_hi[3];
  int m_rd;

  always @(posedge clk) begin
    int old[3];
    int c, f, src;
    if (rst) begin
      for (int i = 0; i < 3; i++) begin
        m_div[i] = 0; m_cnt[i] = 0; m_snap[i] = 0; m_fmt[i] = 3;
        m_cfg[i] = 0; m_lat[i] = 0; m_hi[i] = 0;
      end
      m_rd = 0;
    end else begin
      for (int i = 0; i < 3; i++) begin
        old[i] = m_cnt[i];
        if (cnt_en[i]) m_cnt[i] = (old[i] == 1) ? m_div[i] : ((old[i] - 1) & 16'hFFFF);
      end
      if (wr_en) begin
        if (addr == 3) begin
          c = wdata[7:6]; f = wdata[5:4];
          if (c < 3) begin
            if (f == 0) begin
              if (!m_lat[c]) begin m_snap[c] = old[c]; m_lat[c] = 1; end
            end else begin
              m_fmt[c] = f; m_cfg[c] = wdata[3:0]; m_lat[c] = 0; m_hi[c] = (f == 2);
            end
          end
        end else begin
          c = addr;
          if (m_fmt[c] == 1) begin
            m_div[c] = (m_div[c] & 16'hFF00) | wdata; m_cnt[c] = m_div[c]; m_lat[c] = 0;
          end else if (m_fmt[c] == 2) begin
            m_div[c] = (m_div[c] & 16'h00FF) | (int'(wdata) << 8); m_cnt[c] = m_div[c]; m_lat[c] = 0;
          end else if (m_hi[c]) begin
            m_div[c] = (m_div[c] & 16'h00FF) | (int'(wdata) << 8); m_cnt[c] = m_div[c];
            m_lat[c] = 0; m_hi[c] = 0;
          end else begin
            m_div[c] = (m_div[c] & 16'hFF00) | wdata; m_hi[c] = 1;
          end
        end
      end else if (rd_en) begin
        if (addr == 3) m_rd = 0;
        else begin
          c = addr;
          src = m_lat[c] ? m_snap[c] : old[c];
          if (m_fmt[c] == 1) begin m_rd = src & 8'hFF; m_lat[c] = 0; end
          else if (m_fmt[c] == 2) begin m_rd = (src >> 8) & 8'hFF; m_lat[c] = 0; end
          else if (m_hi[c]) begin m_rd = (src >> 8) & 8'hFF; m_hi[c] = 0; m_lat[c] = 0; end
          else begin m_rd = src & 8'hFF; m_hi[c] = 1; end
        end
      end
    end
  end

  // Per-clock comparison against the model
  always @(negedge clk) begin
    logic [11:0] exp_cfg;
    exp_cfg = {m_cfg[2][3:0], m_cfg[1][3:0], m_cfg[0][3:0]};
    checks++;
    if (rdata !== m_rd[7:0] || chan_cfg !== exp_cfg) begin
      fails++;
      $display("FAIL model %s at %0t: rdata=%h chan_cfg=%h expected rdata=%h chan_cfg=%h",
               cur_req, $time, rdata, chan_cfg, m_rd[7:0], exp_cfg);
    end
  end

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd_chk(input logic [1:0] a, input int exp, input string req);
    addr = a; rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
    check(req, rdata, exp);
  endtask

  task automatic run(input int ch, input int n);
    cnt_en[ch] = 1'b1;
    repeat (n) @(negedge clk);
    cnt_en[ch] = 1'b0;
  endtask

  task automatic summary;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    #(200000 * 4);
    fails++; checks++;
    $display("FAIL watchdog R10: actual=hung expected=done");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R10 rdata", rdata, 0);
    check("R10 chan_cfg", chan_cfg, 0);
    rst = 1'b0;
    cur_req = "R10";
    rd_chk(0, 8'h00, "R10");
    rd_chk(0, 8'h00, "R10");

    cur_req = "R3";
    wr(3, 8'h36);
    check("R1 cfg ch0", chan_cfg, 12'h006);
    wr(0, 8'h34); wr(0, 8'h12);
    cur_req = "R6";
    rd_chk(0, 8'h34, "R6"); rd_chk(0, 8'h12, "R6");

    cur_req = "R7";
    run(0, 4);
    wr(3, 8'h00);
    run(0, 3);
    rd_chk(0, 8'h30, "R7"); rd_chk(0, 8'h12, "R6");
    rd_chk(0, 8'h2D, "R6"); rd_chk(0, 8'h12, "R6");
    wr(3, 8'h00);
    run(0, 2);
    wr(3, 8'h00);
    rd_chk(0, 8'h2D, "R7"); rd_chk(0, 8'h12, "R7");
    rd_chk(0, 8'h2B, "R7"); rd_chk(0, 8'h12, "R7");

    cur_req = "R4";
    wr(3, 8'h53);
    check("R1 cfg ch1", chan_cfg, 12'h036);
    wr(1, 8'h03);
    run(1, 3);
    rd_chk(1, 8'h03, "R4");
    run(1, 2);
    rd_chk(1, 8'h01, "R4");

    cur_req = "R2";
    wr(3, 8'h61);
    check("R1 cfg ch1 hi", chan_cfg, 12'h016);
    wr(1, 8'h80);
    rd_chk(1, 8'h80, "R2");
    cur_req = "R5";
    wr(3, 8'h50);
    wr(3, 8'h40);
    run(1, 1);
    rd_chk(1, 8'h03, "R5");
    rd_chk(1, 8'h02, "R5");

    cur_req = "R4";
    wr(3, 8'hB0);
    wr(2, 8'h00); wr(2, 8'h00);
    run(2, 1);
    rd_chk(2, 8'hFF, "R4"); rd_chk(2, 8'hFF, "R4");

    cur_req = "R8";
    run(2, 1);
    rd_chk(2, 8'hFE, "R8");
    rd_chk(3, 8'h00, "R8");
    rd_chk(2, 8'hFF, "R8");

    cur_req = "R1";
    wr(3, 8'hF6);
    check("R1 ignored select", chan_cfg, 12'h006);

    cur_req = "R9";
    addr = 2; wdata = 8'h05; wr_en = 1'b1; rd_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0; rd_en = 1'b0;
    check("R9 read dropped", rdata, 8'hFF);
    wr(2, 8'h00);
    rd_chk(2, 8'h05, "R9"); rd_chk(2, 8'h00, "R9");

    cur_req = "R3";
    wr(2, 8'h09);
    wr(3, 8'h80);
    rd_chk(2, 8'h00, "R3");
    rd_chk(2, 8'h05, "R3");
    rd_chk(2, 8'h00, "R3");
    wr(2, 8'h09); wr(2, 8'h00);
    rd_chk(2, 8'h09, "R3"); rd_chk(2, 8'h00, "R3");

    cur_req = "R1";
    wr(3, 8'h80);
    run(2, 2);
    wr(3, 8'hB0);
    rd_chk(2, 8'h07, "R1"); rd_chk(2, 8'h00, "R1");

    cur_req = "R10";
    rst = 1'b1;
    repeat (2) @(negedge clk);
    check("R10 rdata again", rdata, 0);
    check("R10 chan_cfg again", chan_cfg, 0);
    rst = 1'b0;
    rd_chk(0, 8'h00, "R10"); rd_chk(0, 8'h00, "R10");

    repeat (2) @(negedge clk);
    summary();
  end
endmodule